// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the two inputs of a phase-frequency detector, the reference and the feedback, and reports whether the loop is locked. Both inputs are sampled by a fast sampling clock. On each PFD cycle the block counts how many sampling-clock cycles separate the two rising edges. The count is the same whichever edge comes first.

The lock flag rises only after a programmable run of consecutive cycles, all inside a narrow lock window. Once the flag is set, a single cycle beyond a wider unlock window clears it. Edge differences between the two thresholds neither build a run nor break a lock, so the flag does not chatter during acquisition. A 1-bit input selects one of two threshold pairs. A 2-bit input selects the run length. For correct results the PFD period must be longer than the unlock threshold.

Top module: `pll_lock_detect`

## Requirements
- R1: During and after reset, `locked` is 0 and the good-cycle run is empty.
- R2: A PFD cycle is good when the edge difference in sampling cycles is strictly below the lock threshold. `locked` rises after the selected number of consecutive good cycles, and not before.
- R3: While unlocked, a cycle that is not good (difference at or above the lock threshold, or a timeout) empties the good-cycle run.
- R4: While locked, a cycle whose difference is at or below the unlock threshold keeps `locked` at 1. This holds even when the difference lies between the lock and unlock thresholds.
- R5: While locked, one cycle whose difference exceeds the unlock threshold clears `locked`.
- R6: If the second edge has not arrived once the difference has reached the unlock threshold, the cycle is judged failing, exactly as if the difference exceeded the unlock threshold.
- R7: The difference is measured the same way whether the reference edge or the feedback edge arrives first.
- R8: `cnt_sel` selects the run length: 0 selects 5 cycles, 1 selects 16, 2 selects 64 and 3 selects 255.
- R9: With `win_sel` = 0 the lock/unlock thresholds are 3/7 sampling cycles. With `win_sel` = 1 they are 6/14.
- R10: Rising edges on both inputs in the same sampling cycle give a difference of 0, which is a good cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Reference input of the PFD, synchronous to clk |
| fb_in | input | 1 | Feedback input of the PFD, synchronous to clk |
| win_sel | input | 1 | Threshold pair select |
| cnt_sel | input | 2 | Consecutive good-cycle count select |
| locked | output | 1 | Lock flag |

## Verification
Each fault inside the block shows up at the single `locked` output. A wrong run counter or a wrong count decode moves the lock assertion by one or more PFD cycles. An off-by-one threshold comparison shows at the boundary differences 2/3, 7/8, 5/6 and 14/15. Each of these appears within two sampling cycles after the PFD cycle that should have decided it. A stuck edge-order or timeout path is exposed by feedback-first cycles and by cycles with a missing second edge.

// File: rtl/pld_pkg.sv
package pld_pkg;
   typedef enum logic {MS_IDLE, MS_WAIT} meas_state_e;

   typedef struct packed {
      logic valid;
      logic good;
      logic bad;
   } meas_res_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/pld_edge_detect.sv
module pld_edge_detect #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev;

   for (genvar i = 0; i < N; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[i] <= 1'b0;
         else        prev[i] <= sig[i];
      end
      assign rise[i] = sig[i] & ~prev[i];
   end
endmodule

// File: rtl/pld_phase_meas.sv
module pld_phase_meas
   import pld_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_ref,
   input  logic          rise_fb,
   input  logic [TW-1:0] lock_thr,
   input  logic [TW-1:0] unlock_thr,
   output meas_res_t     res,
   output logic [TW-1:0] wait_cnt
);
   meas_state_e state;
   logic        ref_lead;
   logic        other;

   assign other = ref_lead ? rise_fb : rise_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= MS_IDLE;
         ref_lead <= 1'b0;
         wait_cnt <= '0;
         res      <= '0;
      end else begin
         res <= '0;
         case (state)
            MS_IDLE: begin
               wait_cnt <= '0;
               if (rise_ref && rise_fb) begin
                  res.valid <= 1'b1;
                  res.good  <= (lock_thr != '0);
               end else if (rise_ref || rise_fb) begin
                  state    <= MS_WAIT;
                  ref_lead <= rise_ref;
                  wait_cnt <= TW'(1);
               end
            end
            MS_WAIT: begin
               if (other) begin
                  res.valid <= 1'b1;
                  res.good  <= (wait_cnt < lock_thr);
                  res.bad   <= (wait_cnt > unlock_thr);
                  state     <= MS_IDLE;
                  wait_cnt  <= '0;
               end else if (wait_cnt >= unlock_thr) begin
                  res.valid <= 1'b1;
                  res.bad   <= 1'b1;
                  state     <= MS_IDLE;
                  wait_cnt  <= '0;
               end else begin
                  wait_cnt <= wait_cnt + TW'(1);
               end
            end
            default: state <= MS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
   import pld_pkg::*;
#(
   parameter int RUN_W = 8,
   parameter int CNT0  = 5,
   parameter int CNT1  = 16,
   parameter int CNT2  = 64,
   parameter int CNT3  = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  meas_res_t        res,
   input  logic [1:0]       cnt_sel,
   output logic             locked,
   output logic [RUN_W-1:0] run_cnt
);
   logic [RUN_W-1:0] last_idx;

   always_comb begin
      case (cnt_sel)
         2'd0:    last_idx = RUN_W'(CNT0 - 1);
         2'd1:    last_idx = RUN_W'(CNT1 - 1);
         2'd2:    last_idx = RUN_W'(CNT2 - 1);
         default: last_idx = RUN_W'(CNT3 - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked  <= 1'b0;
         run_cnt <= '0;
      end else if (res.valid) begin
         if (locked) begin
            run_cnt <= '0;
            if (res.bad) locked <= 1'b0;
         end else if (res.good) begin
            if (run_cnt >= last_idx) begin
               locked  <= 1'b1;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + RUN_W'(1);
            end
         end else begin
            run_cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
   import pld_pkg::*;
#(
   parameter int TW        = 8,
   parameter int LOCK_T0   = 3,
   parameter int UNLOCK_T0 = 7,
   parameter int LOCK_T1   = 6,
   parameter int UNLOCK_T1 = 14,
   parameter int CNT0      = 5,
   parameter int CNT1      = 16,
   parameter int CNT2      = 64,
   parameter int CNT3      = 255
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_in,
   input  logic       fb_in,
   input  logic       win_sel,
   input  logic [1:0] cnt_sel,
   output logic       locked
);
   localparam int RUN_MAX = max4(CNT0, CNT1, CNT2, CNT3);
   localparam int RUN_W   = $clog2(RUN_MAX + 1);

   if (LOCK_T0 < 1 || LOCK_T1 < 1) begin : g_chk_lock
      $error("lock thresholds must be at least 1");
   end
   if (UNLOCK_T0 <= LOCK_T0 || UNLOCK_T1 <= LOCK_T1) begin : g_chk_hyst
      $error("unlock threshold must exceed lock threshold");
   end
   if (UNLOCK_T0 >= (1 << TW) - 1 || UNLOCK_T1 >= (1 << TW) - 1) begin : g_chk_tw
      $error("TW too narrow for unlock thresholds");
   end
   if (CNT0 < 1 || CNT1 < 1 || CNT2 < 1 || CNT3 < 1) begin : g_chk_cnt
      $error("run lengths must be at least 1");
   end

   logic [1:0]       rise;
   logic [TW-1:0]    lock_thr, unlock_thr, wait_cnt;
   meas_res_t        res;
   logic [RUN_W-1:0] run_cnt;
   logic             meas_valid, meas_good, meas_bad;

   assign lock_thr   = win_sel ? TW'(LOCK_T1)   : TW'(LOCK_T0);
   assign unlock_thr = win_sel ? TW'(UNLOCK_T1) : TW'(UNLOCK_T0);
   assign meas_valid = res.valid;
   assign meas_good  = res.good;
   assign meas_bad   = res.bad;

   pld_edge_detect #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig({fb_in, ref_in}), .rise(rise)
   );

   pld_phase_meas #(.TW(TW)) u_meas (
      .clk(clk), .rst_n(rst_n), .rise_ref(rise[0]), .rise_fb(rise[1]),
      .lock_thr(lock_thr), .unlock_thr(unlock_thr), .res(res), .wait_cnt(wait_cnt)
   );

   pld_lock_fsm #(
      .RUN_W(RUN_W), .CNT0(CNT0), .CNT1(CNT1), .CNT2(CNT2), .CNT3(CNT3)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .res(res), .cnt_sel(cnt_sel),
      .locked(locked), .run_cnt(run_cnt)
   );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk #(
   parameter int TW    = 8,
   parameter int RUN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             locked,
   input logic             meas_valid,
   input logic             meas_good,
   input logic             meas_bad,
   input logic [RUN_W-1:0] run_cnt,
   input logic [TW-1:0]    wait_cnt,
   input logic [TW-1:0]    unlock_thr
);
   a_r2_lock_after_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(meas_valid && meas_good));

   a_r5_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(meas_valid && meas_bad));

   a_r4_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && meas_valid && !meas_bad) |=> locked);

   a_r3_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && meas_valid && !meas_good) |=> (run_cnt == '0));

   a_r6_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= unlock_thr);

   a_r5_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({meas_good, meas_bad}));
endmodule

bind pll_lock_detect pll_lock_detect_chk #(.TW(TW), .RUN_W(RUN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .locked(locked), .meas_valid(meas_valid),
   .meas_good(meas_good), .meas_bad(meas_bad), .run_cnt(run_cnt),
   .wait_cnt(wait_cnt), .unlock_thr(unlock_thr)
);

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
   localparam int PER = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       fb_in = 1'b0;
   logic       win_sel = 1'b0;
   logic [1:0] cnt_sel = 2'd0;
   logic       locked;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pll_lock_detect uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .win_sel(win_sel), .cnt_sel(cnt_sel), .locked(locked)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s locked actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic ws, input logic [1:0] cs);
      @(negedge clk);
      rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
      win_sel = ws; cnt_sel = cs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // lag < 0: second edge never arrives
   task automatic pfd_cycle(input int lag, input bit fb_lead);
      for (int c = 0; c < PER; c++) begin
         @(negedge clk);
         if (fb_lead) begin
            fb_in  = (c >= 2 && c < 4);
            ref_in = (lag >= 0 && c >= 2 + lag && c < 4 + lag);
         end else begin
            ref_in = (c >= 2 && c < 4);
            fb_in  = (lag >= 0 && c >= 2 + lag && c < 4 + lag);
         end
      end
   endtask

   task automatic good_run(input int n, input int lag, input bit fb_lead);
      for (int i = 0; i < n; i++) pfd_cycle(lag, fb_lead);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 during reset", locked, 1'b0);
      do_reset(1'b0, 2'd0);
      check("R1 after reset", locked, 1'b0);
   endtask

   task automatic t_lock_count;
      do_reset(1'b0, 2'd0);
      good_run(4, 2, 1'b0);
      check("R2 four good cycles", locked, 1'b0);
      pfd_cycle(1, 1'b0);
      check("R2 fifth good cycle", locked, 1'b1);
   endtask

   task automatic t_run_reset;
      do_reset(1'b0, 2'd0);
      good_run(4, 2, 1'b0);
      pfd_cycle(3, 1'b0);
      good_run(4, 2, 1'b0);
      check("R3 run restarted by diff 3", locked, 1'b0);
      pfd_cycle(2, 1'b0);
      check("R3 lock after fresh run", locked, 1'b1);
      do_reset(1'b0, 2'd0);
      good_run(4, 1, 1'b0);
      pfd_cycle(-1, 1'b0);
      good_run(4, 1, 1'b0);
      check("R3 R6 run restarted by timeout", locked, 1'b0);
   endtask

   task automatic t_hyst;
      do_reset(1'b0, 2'd0);
      good_run(5, 0, 1'b0);
      check("R10 simultaneous edges lock", locked, 1'b1);
      pfd_cycle(3, 1'b0);
      check("R4 diff 3 holds", locked, 1'b1);
      pfd_cycle(7, 1'b0);
      check("R4 diff 7 holds", locked, 1'b1);
      pfd_cycle(8, 1'b0);
      check("R5 diff 8 drops", locked, 1'b0);
   endtask

   task automatic t_timeout;
      do_reset(1'b0, 2'd0);
      good_run(5, 2, 1'b0);
      check("R6 locked before timeout", locked, 1'b1);
      pfd_cycle(-1, 1'b0);
      check("R6 missing edge drops", locked, 1'b0);
   endtask

   task automatic t_fb_first;
      do_reset(1'b0, 2'd0);
      good_run(4, 2, 1'b1);
      check("R7 fb-first four cycles", locked, 1'b0);
      pfd_cycle(2, 1'b1);
      check("R7 fb-first lock", locked, 1'b1);
      pfd_cycle(7, 1'b1);
      check("R7 fb-first diff 7 holds", locked, 1'b1);
      pfd_cycle(8, 1'b1);
      check("R7 fb-first diff 8 drops", locked, 1'b0);
   endtask

   task automatic t_count_sel(input logic [1:0] cs, input int n);
      do_reset(1'b0, cs);
      good_run(n - 1, 1, 1'b0);
      check($sformatf("R8 sel %0d one short", cs), locked, 1'b0);
      pfd_cycle(1, 1'b0);
      check($sformatf("R8 sel %0d reached", cs), locked, 1'b1);
   endtask

   task automatic t_window;
      do_reset(1'b0, 2'd0);
      good_run(5, 5, 1'b0);
      check("R9 win0 diff 5 not good", locked, 1'b0);
      do_reset(1'b1, 2'd0);
      good_run(4, 5, 1'b0);
      check("R9 win1 four cycles", locked, 1'b0);
      pfd_cycle(5, 1'b0);
      check("R9 win1 diff 5 locks", locked, 1'b1);
      pfd_cycle(14, 1'b0);
      check("R9 win1 diff 14 holds", locked, 1'b1);
      pfd_cycle(15, 1'b0);
      check("R9 win1 diff 15 drops", locked, 1'b0);
      do_reset(1'b1, 2'd0);
      good_run(4, 5, 1'b0);
      pfd_cycle(6, 1'b0);
      good_run(4, 5, 1'b0);
      check("R9 win1 diff 6 restarts run", locked, 1'b0);
   endtask

   initial begin
      t_reset();
      t_lock_count();
      t_run_reset();
      t_hyst();
      t_timeout();
      t_fb_first();
      t_count_sel(2'd1, 16);
      t_count_sel(2'd2, 64);
      t_count_sel(2'd3, 255);
      t_window();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule